// File: doc/BRIEF.md
# Refresh-Paced Memory Scrubber

This block repairs soft errors in an error-corrected memory by reusing the refresh schedule. Every refresh event asks it to scrub one word. It reads the word at its address pointer through the memory's error-correction path. If the correction logic reports a single-bit (correctable) error, it writes the corrected word back to the same address, and the write path of the memory adds fresh check bits. A double-bit (uncorrectable) error cannot be repaired: the scrubber records the address and raises an interrupt pulse. In every case it then moves its pointer to the next word, and it wraps to zero after a programmable top address.

The pointer steps through the whole memory, so each word is visited once per sweep. A single-bit error is therefore cleaned before a second upset can land in the same word and make it uncorrectable. Refresh events that arrive while a scrub is in progress are counted and served later. An enable input pauses the scrubber without losing its place. Arbitration against host traffic is outside the block and is seen only as a request/grant handshake.

Top module: `refresh_scrubber`

## Requirements
- R1: Every pulse on `refresh_req_i` leads to exactly one scrub read. Pulses that arrive while a scrub is in progress are counted, up to 2^PEND_W-1 outstanding, and served in turn.
- R2: A scrub read shows `mem_req_o`=1 and `mem_we_o`=0 at the pointer address. It holds the request, the address and the write flag stable until a cycle with `mem_gnt_i`=1.
- R3: When the read data returns (`mem_rvalid_i`=1) with `edac_ce_i`=0 and `edac_ue_i`=0, no write is issued.
- R4: When the read returns with `edac_ce_i`=1 and `edac_ue_i`=0, exactly one write (`mem_we_o`=1) is issued to the same address, carrying `edac_data_i` from the read, before the pointer advances.
- R5: When the read returns with `edac_ue_i`=1, this takes precedence over `edac_ce_i` and no write is issued. `ue_irq_o` pulses high for one cycle, and `ue_addr_o` holds that address until the next uncorrectable error.
- R6: After each scrub the pointer increments by one. After the scrub of `top_addr_i`, or of any higher address, it wraps to zero instead. `sweep_done_o` pulses for one cycle on each wrap.
- R7: While `enable_i`=0 no new scrub starts. The pointer and the count of outstanding refresh events are kept, so scrubbing resumes at the same address once `enable_i` returns to 1.
- R8: With `rst` high, the pointer and the outstanding count go to zero, and `mem_req_o`, `busy_o`, `ue_irq_o`, `sweep_done_o` and `ue_addr_o` all go to zero.
- R9: `busy_o` is high from the cycle after a scrub starts until the scrubber is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Allows new scrubs to start |
| top_addr_i | input | ADDR_W | Highest address in the sweep |
| refresh_req_i | input | 1 | One-cycle pulse per refresh event |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Access address |
| mem_wdata_o | output | DATA_W | Corrected write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read result valid |
| edac_ce_i | input | 1 | Correctable error on the read |
| edac_ue_i | input | 1 | Uncorrectable error on the read |
| edac_data_i | input | DATA_W | Corrected read data |
| busy_o | output | 1 | Scrub in progress |
| sweep_done_o | output | 1 | Pulse on pointer wrap |
| ue_irq_o | output | 1 | Pulse on uncorrectable error |
| ue_addr_o | output | ADDR_W | Address of the last uncorrectable error |

## Verification
The assertions assume that the memory side behaves as a well-formed responder. The grant appears only while a request is raised. A read result arrives only after a granted read. The error flags are meaningful only when a read result is valid. The bench's memory model grants from the request through a stall pattern, returns the result one cycle after a granted read, and derives the flags from a per-address fault table, so the stimulus stays inside these assumptions. The stall pattern also exercises the hold-until-grant rule.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_DONE
  } scrub_state_e;
endpackage

// File: rtl/scrub_pending.sv
// Counts refresh events that still owe a scrub.
module scrub_pending #(
  parameter int PEND_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic incr_i,
  input  logic take_i,
  output logic work_o
);
  localparam logic [PEND_W-1:0] MAX = {PEND_W{1'b1}};

  logic [PEND_W-1:0] cnt_q;
  logic              take_ok;

  assign take_ok = take_i && (cnt_q != '0);
  assign work_o  = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      case ({incr_i, take_ok})
        2'b10:   if (cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R1: a refresh event with no scrub taken is remembered
  assert_refresh_counted_R1: assert property (@(posedge clk) disable iff (rst)
    (incr_i && !take_i && cnt_q != MAX) |=> (cnt_q == $past(cnt_q) + PEND_W'(1)));
endmodule

// File: rtl/scrub_addr_ptr.sv
// Sweep pointer with wrap at a programmable top address.
module scrub_addr_ptr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] top_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              wrap_o
);
  logic [ADDR_W-1:0] ptr_q;
  logic              wrap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (step_i) begin
        if (ptr_q >= top_i) begin
          ptr_q  <= '0;
          wrap_q <= 1'b1;
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  end

  assign ptr_o  = ptr_q;
  assign wrap_o = wrap_q;

  assert_ptr_incr_R6: assert property (@(posedge clk) disable iff (rst)
    (step_i && ptr_q < top_i) |=> (ptr_q == $past(ptr_q) + ADDR_W'(1) && !wrap_q));
  assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (step_i && ptr_q >= top_i) |=> (ptr_q == '0 && wrap_q));
  // R7: the pointer only moves on a completed scrub
  assert_ptr_kept_R7: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(ptr_q));
endmodule

// File: rtl/scrub_fsm.sv
// One scrub: read, optional write-back, then report.
module scrub_fsm
  import scrub_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable_i,
  input  logic              work_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              take_o,
  output logic              step_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic              edac_ce_i,
  input  logic              edac_ue_i,
  input  logic [DATA_W-1:0] edac_data_i,
  output logic              busy_o,
  output logic              ue_irq_o,
  output logic [ADDR_W-1:0] ue_addr_o
);
  scrub_state_e      state_q;
  logic [DATA_W-1:0] wdata_q;
  logic              irq_q;
  logic [ADDR_W-1:0] ue_addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      wdata_q   <= '0;
      irq_q     <= 1'b0;
      ue_addr_q <= '0;
    end else begin
      irq_q <= 1'b0;
      case (state_q)
        ST_IDLE:    if (enable_i && work_i) state_q <= ST_RD_REQ;
        ST_RD_REQ:  if (mem_gnt_i) state_q <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (mem_rvalid_i) begin
            if (edac_ue_i) begin
              irq_q     <= 1'b1;
              ue_addr_q <= addr_i;
              state_q   <= ST_DONE;
            end else if (edac_ce_i) begin
              wdata_q <= edac_data_i;
              state_q <= ST_WR_REQ;
            end else begin
              state_q <= ST_DONE;
            end
          end
        end
        ST_WR_REQ:  if (mem_gnt_i) state_q <= ST_DONE;
        ST_DONE:    state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign take_o      = (state_q == ST_IDLE) && enable_i && work_i;
  assign step_o      = (state_q == ST_DONE);
  assign mem_req_o   = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign mem_we_o    = (state_q == ST_WR_REQ);
  assign mem_wdata_o = wdata_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign ue_irq_o    = irq_q;
  assign ue_addr_o   = ue_addr_q;

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_we_o) && $stable(addr_i)));
  assert_write_after_ce_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_o) |-> $past(mem_rvalid_i && edac_ce_i && !edac_ue_i));
  assert_no_write_on_ue_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RD_WAIT && mem_rvalid_i && edac_ue_i) |=> !mem_req_o);
  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    ue_irq_o |=> !ue_irq_o);
  assert_hold_when_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    (!enable_i && !busy_o) |=> !busy_o);
endmodule

// File: rtl/refresh_scrubber.sv
module refresh_scrubber #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable_i,
  input  logic [ADDR_W-1:0] top_addr_i,
  input  logic              refresh_req_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic              edac_ce_i,
  input  logic              edac_ue_i,
  input  logic [DATA_W-1:0] edac_data_i,
  output logic              busy_o,
  output logic              sweep_done_o,
  output logic              ue_irq_o,
  output logic [ADDR_W-1:0] ue_addr_o
);
  logic              work;
  logic              take;
  logic              step;
  logic [ADDR_W-1:0] ptr;

  scrub_pending #(.PEND_W(PEND_W)) u_pending (
    .clk    (clk),
    .rst    (rst),
    .incr_i (refresh_req_i),
    .take_i (take),
    .work_o (work)
  );

  scrub_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .step_i (step),
    .top_i  (top_addr_i),
    .ptr_o  (ptr),
    .wrap_o (sweep_done_o)
  );

  scrub_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .enable_i     (enable_i),
    .work_i       (work),
    .addr_i       (ptr),
    .take_o       (take),
    .step_o       (step),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .edac_ce_i    (edac_ce_i),
    .edac_ue_i    (edac_ue_i),
    .edac_data_i  (edac_data_i),
    .busy_o       (busy_o),
    .ue_irq_o     (ue_irq_o),
    .ue_addr_o    (ue_addr_o)
  );

  assign mem_addr_o = ptr;
endmodule

// File: tb/refresh_scrubber_bench.sv
`timescale 1ns/1ps
module refresh_scrubber_bench;
  localparam int AW  = 8;
  localparam int DW  = 32;
  localparam int TOP = 5;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } op_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b1;
  logic refresh = 1'b0;
  logic [AW-1:0] top_addr = AW'(TOP);
  logic mem_req, mem_we, mem_gnt, mem_rvalid, edac_ce, edac_ue;
  logic [AW-1:0] mem_addr, ue_addr;
  logic [DW-1:0] mem_wdata, edac_data;
  logic busy, sweep_done, ue_irq;
  logic gnt_allow;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int sweeps_seen = 0;
  int sweeps_exp = 0;
  bit quiet = 1'b0;
  bit finished = 1'b0;

  op_t           exp_q[$];
  logic [AW-1:0] ue_q[$];
  logic [1:0]    mem_err[256];  // 0 clean, 1 correctable, 2 uncorrectable
  logic [1:0]    mdl_err[256];
  int            mdl_ptr = 0;

  always #2.5 clk = ~clk;

  refresh_scrubber #(.ADDR_W(AW), .DATA_W(DW), .PEND_W(4)) u_refresh_scrubber (
    .clk(clk), .rst(rst), .enable_i(enable), .top_addr_i(top_addr),
    .refresh_req_i(refresh), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt),
    .mem_rvalid_i(mem_rvalid), .edac_ce_i(edac_ce), .edac_ue_i(edac_ue),
    .edac_data_i(edac_data), .busy_o(busy), .sweep_done_o(sweep_done),
    .ue_irq_o(ue_irq), .ue_addr_o(ue_addr)
  );

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return 32'hC0DE_0000 | DW'(a);
  endfunction

  // memory + correction model
  assign mem_gnt = mem_req && gnt_allow;
  always @(posedge clk) begin
    cycles     <= cycles + 1;
    gnt_allow  <= (cycles % 3) != 1;
    mem_rvalid <= mem_req && mem_gnt && !mem_we;
    edac_ce    <= mem_req && mem_gnt && !mem_we && mem_err[mem_addr] == 2'd1;
    edac_ue    <= mem_req && mem_gnt && !mem_we && mem_err[mem_addr] == 2'd2;
    edac_data  <= word_of(mem_addr);
    if (mem_req && mem_gnt && mem_we) mem_err[mem_addr] <= 2'd0;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req && mem_gnt) begin
        if (quiet) check(1'b0, "R7", "access while disabled", mem_addr, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "unexpected access", {mem_we, mem_addr}, 0);
        end else begin
          op_t e;
          e = exp_q.pop_front();
          check(mem_we == e.we, "R3/R4", "read/write kind", mem_we, e.we);
          check(mem_addr == e.addr, "R2/R6", "access address", mem_addr, e.addr);
          if (e.we) check(mem_wdata == e.data, "R4", "write-back data", mem_wdata, e.data);
        end
      end
      if (ue_irq) begin
        if (ue_q.size() == 0) check(1'b0, "R5", "unexpected irq", ue_addr, 0);
        else begin
          logic [AW-1:0] ea;
          ea = ue_q.pop_front();
          check(ue_addr == ea, "R5", "ue address", ue_addr, ea);
        end
      end
      if (sweep_done) sweeps_seen++;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    if (cycles >= 20000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  // driver: pulse a refresh and push what it must cause
  task automatic refresh_pulse();
    @(negedge clk) refresh = 1'b1;
    exp_q.push_back('{we: 1'b0, addr: AW'(mdl_ptr), data: '0});
    if (mdl_err[mdl_ptr] == 2'd1) begin
      exp_q.push_back('{we: 1'b1, addr: AW'(mdl_ptr), data: word_of(AW'(mdl_ptr))});
      mdl_err[mdl_ptr] = 2'd0;
    end else if (mdl_err[mdl_ptr] == 2'd2) begin
      ue_q.push_back(AW'(mdl_ptr));
    end
    if (mdl_ptr >= TOP) begin
      mdl_ptr = 0;
      sweeps_exp++;
    end else mdl_ptr++;
    @(negedge clk) refresh = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !busy) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem_err[i] = 2'd0;
      mdl_err[i] = 2'd0;
    end
    mem_err[1] = 2'd1; mdl_err[1] = 2'd1;
    mem_err[3] = 2'd2; mdl_err[3] = 2'd2;
    mem_err[4] = 2'd1; mdl_err[4] = 2'd1;
    gnt_allow = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    check(mem_req == 1'b0, "R8", "mem_req after reset", mem_req, 0);
    check(busy == 1'b0, "R8", "busy after reset", busy, 0);
    check(ue_irq == 1'b0, "R8", "ue_irq after reset", ue_irq, 0);
    check(sweep_done == 1'b0, "R8", "sweep_done after reset", sweep_done, 0);
    check(ue_addr == '0, "R8", "ue_addr after reset", ue_addr, 0);

    // one refresh at a time over a full sweep (clean, CE, UE words)
    refresh_pulse();
    @(negedge clk);
    check(busy == 1'b1, "R9", "busy during scrub", busy, 1);
    wait_idle();
    check(busy == 1'b0, "R9", "busy after scrub", busy, 0);
    for (int k = 0; k < 5; k++) begin
      refresh_pulse();
      wait_idle();
    end
    check(sweeps_seen == 1, "R6", "sweep pulses after first sweep", sweeps_seen, 1);

    // R1: back-to-back refresh pulses while busy are all served
    for (int k = 0; k < 4; k++) refresh_pulse();
    wait_idle();
    check(exp_q.size() == 0, "R1", "burst fully served", exp_q.size(), 0);

    // R7: disabled scrubber keeps pointer and counts requests
    enable = 1'b0;
    @(negedge clk);
    quiet = 1'b1;
    for (int k = 0; k < 3; k++) refresh_pulse();
    repeat (40) @(negedge clk);
    check(busy == 1'b0, "R7", "idle while disabled", busy, 0);
    check(exp_q.size() == 3, "R7", "no scrub while disabled", exp_q.size(), 3);
    quiet = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    wait_idle();

    // second pass: repaired words now clean, UE word still reported
    for (int k = 0; k < 5; k++) begin
      refresh_pulse();
      wait_idle();
    end
    check(exp_q.size() == 0, "R4", "all expected accesses seen", exp_q.size(), 0);
    check(ue_q.size() == 0, "R5", "all expected irqs seen", ue_q.size(), 0);
    check(ue_addr == AW'(3), "R5", "ue_addr held", ue_addr, 3);
    check(sweeps_seen == sweeps_exp, "R6", "sweep pulse count", sweeps_seen, sweeps_exp);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule